// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block moves received frames from a byte stream into system memory. Memory holds a ring of descriptors, each four 32-bit words (16 bytes) long. Word 1 of a descriptor holds the address of a receive buffer, and every buffer is a fixed 2048 bytes. Before each frame the engine reads word 1 of the descriptor at its DMA index and writes the frame's bytes into that buffer. It then writes a completion word into word 2 and moves its DMA index to the next descriptor, wrapping at the configured ring size.

Software hands descriptors back by writing a CPU index, which names the last descriptor it has released. After reset, software sets this index to slot count minus one, which makes the whole ring available. When the DMA index catches up with the CPU index, the ring counts as full. Any frame that arrives while the ring is full is still taken from the stream, but nothing is written to memory, and a drop counter is incremented instead.

The engine has a write-only register port, a byte stream input with a ready signal, a descriptor read port with one cycle of latency, and a 32-bit memory write port with byte enables.

Top module: `rxring_dma_writer`

## Requirements
- R1: While reset is asserted and after it is released, `dma_idx` is 0, `drop_count` is 0, `rx_busy` is 0, `s_ready` is 0 and `mem_we` is 0.
- R2: Before each frame, the engine reads the word at ring base + 16·idx + 4, where the ring base is written at register address 0. It writes payload byte i to byte address buffer + i as a single-lane write: the word address is aligned, `mem_be` has one bit set at the byte lane, and the byte is replicated on all lanes.
- R3: At the end of a frame, the engine writes the word at ring base + 16·idx + 8 with `mem_be` = 4'hF. Bits 31 and 30 are 1, bits [29:16] hold the stored length and bits [15:0] are 0. This word is written only after every payload write of the frame.
- R4: After each completion word, `dma_idx` moves up by one. It wraps from slot count − 1 to 0, where the slot count is written at register address 1.
- R5: The CPU index is written at register address 2. When `dma_idx` equals the CPU index, the next frame is consumed from the stream with no memory write, `dma_idx` is unchanged and `drop_count` rises by exactly one.
- R6: A frame longer than 2048 bytes stores only its first 2048 bytes and reports a length of 2048. A frame of exactly 2048 bytes reports 2048.
- R7: Bit 0 of register address 3 enables the engine. While it is clear and no frame is in progress, `s_ready` stays 0 and nothing is written. If it is cleared in the middle of a frame, that frame still completes with its completion word, and then `rx_busy` falls.
- R8: Writing 1 to bit 0 of register address 4 sets `dma_idx` to 0. If a frame is in progress, the clear waits until that frame's completion word is written and then overrides the advance.
- R9: `rx_busy` is 1 from the first cycle after a frame is accepted until its completion word (or the end of a dropped frame), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 base, 1 slot count, 2 CPU index, 3 control, 4 index clear) |
| reg_wdata | input | 32 | Register write data |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of the frame |
| s_ready | output | 1 | Stream byte accepted on this edge |
| mem_rd_en | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned write address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| rx_busy | output | 1 | Frame in progress |
| dma_idx | output | IDX_W | Descriptor the next frame will use |
| drop_count | output | DROP_W | Frames dropped because the ring was full (wraps) |

## Verification
The bench walks a four-slot ring through frames of lengths 1 to 9, which covers every byte lane and several wraps of the index. A wrap error would send a frame to a descriptor outside the ring. A lane error would corrupt stored bytes even though the completion word reports the correct length. The bench then fills the ring until it is full. An off-by-one in the full test would either overwrite the descriptor that software still holds or drop a frame while a slot is free.

Frames of 2048 and 2050 bytes probe the truncation boundary. A design that gets this wrong either writes past the buffer or reports a length of 2050. The bench also clears the enable and requests an index clear in the middle of a frame. A design that mishandles the enable leaves a completion word missing, and one that mishandles the index clear lets the advance win over the clear.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_STAT,
        ST_DROP
    } rxr_state_e;

    localparam logic [2:0] RA_BASE  = 3'd0;
    localparam logic [2:0] RA_COUNT = 3'd1;
    localparam logic [2:0] RA_CPU   = 3'd2;
    localparam logic [2:0] RA_CTRL  = 3'd3;
    localparam logic [2:0] RA_CLR   = 3'd4;

    localparam int DESC_SHIFT   = 4;   // 16-byte descriptors
    localparam int STAT_LEN_W   = 14;  // length field width in word 2

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      ring_base,
    output logic [IDX_W:0]   slot_count,
    output logic [IDX_W-1:0] cpu_idx,
    output logic             enable,
    output logic             idx_clr
);
    import rxr_pkg::*;

    typedef struct packed {
        logic [31:0]      base;
        logic [IDX_W:0]   count;
        logic [IDX_W-1:0] cpu;
        logic             en;
        logic             clr;
    } regs_t;

    regs_t d, q;

    logic unused_hi;
    assign unused_hi = ^reg_wdata[31:IDX_W+1];

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                RA_BASE:  d.base  = reg_wdata;
                RA_COUNT: d.count = reg_wdata[IDX_W:0];
                RA_CPU:   d.cpu   = reg_wdata[IDX_W-1:0];
                RA_CTRL:  d.en    = reg_wdata[0];
                RA_CLR:   d.clr   = reg_wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ring_base  = q.base;
    assign slot_count = q.count;
    assign cpu_idx    = q.cpu;
    assign enable     = q.en;
    assign idx_clr    = q.clr;

endmodule

// File: rtl/rxr_engine.sv
module rxr_engine #(
    parameter int IDX_W     = 8,
    parameter int BUF_BYTES = 2048,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       ring_base,
    input  logic [IDX_W:0]    slot_count,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              enable,
    input  logic              idx_clr,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              rx_busy,
    output logic [IDX_W-1:0]  dma_idx,
    output logic [DROP_W-1:0] drop_count
);
    import rxr_pkg::*;

    localparam int LEN_W = $clog2(BUF_BYTES) + 1;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(BUF_BYTES);

    typedef struct packed {
        rxr_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [31:0]      bufa;
        logic [LEN_W-1:0] len;
        logic [DROP_W-1:0] drops;
        logic             pend;
    } eng_t;

    eng_t d, q;

    logic [31:0]      desc_addr;
    logic [31:0]      byte_addr;
    logic             ring_full;
    logic             last_slot;

    assign desc_addr = ring_base + 32'({q.idx, {DESC_SHIFT{1'b0}}});
    assign byte_addr = q.bufa + 32'(q.len);
    // The descriptor software last released is never taken by hardware.
    assign ring_full = (q.idx == cpu_idx);
    assign last_slot = ({1'b0, q.idx} == slot_count - (IDX_W+1)'(1));

    always_comb begin
        d           = q;
        s_ready     = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = desc_addr + 32'd4;
        mem_we      = 1'b0;
        mem_addr    = {byte_addr[31:2], 2'b00};
        mem_be      = 4'b0001 << byte_addr[1:0];
        mem_wdata   = {4{s_data}};

        case (q.st)
            ST_IDLE: begin
                if (q.pend) begin
                    d.idx  = '0;
                    d.pend = 1'b0;
                end else if (enable && s_valid) begin
                    if (ring_full) begin
                        d.st    = ST_DROP;
                        d.drops = q.drops + 1'b1;
                    end else begin
                        mem_rd_en = 1'b1;
                        d.st      = ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                d.bufa = mem_rd_data;
                d.len  = '0;
                d.st   = ST_DATA;
            end
            ST_DATA: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    if (q.len < LEN_CAP) begin
                        mem_we = 1'b1;
                        d.len  = q.len + 1'b1;
                    end
                    if (s_last) d.st = ST_STAT;
                end
            end
            ST_STAT: begin
                mem_we    = 1'b1;
                mem_addr  = desc_addr + 32'd8;
                mem_be    = 4'hF;
                mem_wdata = {2'b11, STAT_LEN_W'(q.len), 16'h0000};
                d.idx     = last_slot ? '0 : q.idx + 1'b1;
                d.st      = ST_IDLE;
            end
            ST_DROP: begin
                s_ready = 1'b1;
                if (s_valid && s_last) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (idx_clr) d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_busy    = (q.st != ST_IDLE);
    assign dma_idx    = q.idx;
    assign drop_count = q.drops;

endmodule

// File: rtl/rxring_dma_writer.sv
module rxring_dma_writer #(
    parameter int IDX_W     = 8,
    parameter int BUF_BYTES = 2048,
    parameter int DROP_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic              rx_busy,
    output logic [IDX_W-1:0]  dma_idx,
    output logic [DROP_W-1:0] drop_count
);
    logic [31:0]      ring_base;
    logic [IDX_W:0]   slot_count;
    logic [IDX_W-1:0] cpu_idx;
    logic             enable;
    logic             idx_clr;

    rxr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .ring_base  (ring_base),
        .slot_count (slot_count),
        .cpu_idx    (cpu_idx),
        .enable     (enable),
        .idx_clr    (idx_clr)
    );

    rxr_engine #(
        .IDX_W     (IDX_W),
        .BUF_BYTES (BUF_BYTES),
        .DROP_W    (DROP_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_base   (ring_base),
        .slot_count  (slot_count),
        .cpu_idx     (cpu_idx),
        .enable      (enable),
        .idx_clr     (idx_clr),
        .s_valid     (s_valid),
        .s_data      (s_data),
        .s_last      (s_last),
        .s_ready     (s_ready),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_be      (mem_be),
        .mem_wdata   (mem_wdata),
        .rx_busy     (rx_busy),
        .dma_idx     (dma_idx),
        .drop_count  (drop_count)
    );

endmodule

// File: rtl/rxring_dma_writer_chk.sv
module rxring_dma_writer_chk #(
    parameter int IDX_W     = 8,
    parameter int BUF_BYTES = 2048,
    parameter int DROP_W    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              mem_we,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              rx_busy,
    input logic [IDX_W-1:0]  dma_idx,
    input logic [DROP_W-1:0] drop_count
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_busy |-> (!mem_we && !s_ready));

    // R2
    single_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be != 4'hF) |-> ($countones(mem_be) == 1));

    // R3
    status_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 4'hF) |-> (mem_wdata[31:30] == 2'b11
            && mem_wdata[29:16] != 14'd0
            && 32'(mem_wdata[29:16]) <= BUF_BYTES
            && mem_wdata[15:0] == 16'h0000));

    // R3
    status_ends_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 4'hF) |=> !rx_busy);

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_idx != $past(dma_idx)) |->
            (dma_idx == '0 || dma_idx == IDX_W'($past(dma_idx) + 1'b1)));

    // R5
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
            (drop_count == DROP_W'($past(drop_count) + 1'b1)));

endmodule

bind rxring_dma_writer rxring_dma_writer_chk #(
    .IDX_W     (IDX_W),
    .BUF_BYTES (BUF_BYTES),
    .DROP_W    (DROP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .mem_we     (mem_we),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .rx_busy    (rx_busy),
    .dma_idx    (dma_idx),
    .drop_count (drop_count)
);

// File: tb/rxring_dma_writer_bench.sv
module rxring_dma_writer_bench;
    localparam int IDX_W  = 2;
    localparam int DROP_W = 8;
    localparam int BUFSZ  = 2048;
    localparam int SLOTS  = 4;
    localparam int BASE   = 'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        rx_busy;
    logic [IDX_W-1:0]  dma_idx;
    logic [DROP_W-1:0] drop_count;

    always #5 clk = ~clk;

    rxring_dma_writer #(.IDX_W(IDX_W), .BUF_BYTES(BUFSZ), .DROP_W(DROP_W)) u_rxring_dma_writer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .rx_busy(rx_busy), .dma_idx(dma_idx), .drop_count(drop_count)
    );

    logic [7:0] mem [0:16383];
    int data_cnt, stat_dcnt, oob, cur_buf;
    bit stat_seen;
    int tests = 0, fails = 0;
    bit done = 0;

    function automatic int buf_of(int k);
        return 'h1000 + k * 'h800;
    endfunction

    function automatic logic [7:0] pat(int fid, int i);
        return 8'(fid * 37 + i * 5 + 1);
    endfunction

    function automatic logic [31:0] rd_word(int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= rd_word(int'(mem_rd_addr[13:0]));
        if (mem_we) begin
            for (int l = 0; l < 4; l++) begin
                if (mem_be[l]) begin
                    mem[int'(mem_addr[13:0]) + l] <= mem_wdata[8*l +: 8];
                    if (mem_be != 4'hF &&
                        (int'(mem_addr[13:0]) + l < cur_buf ||
                         int'(mem_addr[13:0]) + l >= cur_buf + BUFSZ))
                        oob <= oob + 1;
                end
            end
            if (mem_be == 4'hF) begin
                stat_seen <= 1'b1;
                stat_dcnt <= data_cnt;
            end else begin
                data_cnt <= data_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bytes(input int fid, input int first, input int n, input int total);
        for (int i = first; i < first + n; i++) begin
            s_valid = 1'b1;
            s_data  = pat(fid, i);
            s_last  = (i == total - 1);
            while (!s_ready) @(negedge clk);
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic wait_idle();
        while (rx_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic arm(input int k);
        cur_buf = buf_of(k);
        data_cnt = 0; stat_seen = 0; stat_dcnt = 0; oob = 0;
        for (int b = 0; b < 4; b++) mem[BASE + 16*k + 8 + b] = 8'h00;
    endtask

    task automatic verify_done(input int fid, input int k, input int len, input string tag);
        int el, mm;
        logic [31:0] exp_w;
        el = (len > BUFSZ) ? BUFSZ : len;
        exp_w = {2'b11, 14'(el), 16'h0000};
        chk(rd_word(BASE + 16*k + 8) == exp_w, {tag, " completion word"},
            int'(rd_word(BASE + 16*k + 8)), int'(exp_w));
        mm = 0;
        for (int i = 0; i < el; i++) if (mem[buf_of(k) + i] != pat(fid, i)) mm++;
        chk(mm == 0, {tag, " R2 payload bytes"}, mm, 0);
        chk(stat_seen && stat_dcnt == el, {tag, " R3 completion after data"}, stat_dcnt, el);
        chk(oob == 0, {tag, " R6 writes inside buffer"}, oob, 0);
        chk(int'(dma_idx) == (k + 1) % SLOTS, {tag, " R4 index advance"}, int'(dma_idx), (k + 1) % SLOTS);
    endtask

    task automatic run_frame(input int fid, input int len, input bit drop, input string tag);
        int k, d0;
        k = int'(dma_idx);
        d0 = int'(drop_count);
        arm(k);
        send_bytes(fid, 0, len, len);
        wait_idle();
        if (!drop) begin
            verify_done(fid, k, len, tag);
        end else begin
            chk(data_cnt == 0 && !stat_seen, {tag, " R5 no writes on drop"}, data_cnt, 0);
            chk(int'(dma_idx) == k, {tag, " R5 index held"}, int'(dma_idx), k);
            chk(int'(drop_count) == d0 + 1, {tag, " R5 drop count"}, int'(drop_count), d0 + 1);
        end
    endtask

    initial begin
        int k, fid;
        for (int i = 0; i < 16384; i++) mem[i] = 8'hA5;
        for (int s = 0; s < SLOTS; s++) begin
            logic [31:0] w;
            w = 32'(buf_of(s));
            for (int b = 0; b < 4; b++) mem[BASE + 16*s + 4 + b] = w[8*b +: 8];
        end

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(dma_idx == 0 && drop_count == 0, "R1 counters in reset", int'(dma_idx), 0);
        chk(!rx_busy && !s_ready && !mem_we, "R1 outputs in reset", int'(rx_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dma_idx == 0 && drop_count == 0, "R1 counters after reset", int'(dma_idx), 0);
        chk(!rx_busy && !s_ready && !mem_we, "R1 outputs after reset", int'(s_ready), 0);

        wr_reg(3'd0, BASE);
        wr_reg(3'd1, SLOTS);
        wr_reg(3'd2, SLOTS - 1);
        wr_reg(3'd3, 1);

        // R2 R3 R4 length and lane sweep, release after each frame
        fid = 1;
        for (int len = 1; len <= 9; len++) begin
            k = int'(dma_idx);
            run_frame(fid, len, 0, "R2 sweep");
            wr_reg(3'd2, k);
            fid++;
        end

        // R5 fill the ring, then one drop
        for (int n = 0; n < 3; n++) begin
            run_frame(fid, 3 + n, 0, "R4 fill");
            fid++;
        end
        chk(!s_ready, "R5 ready low before dropped frame", int'(s_ready), 0);
        run_frame(fid, 6, 1, "R5 full ring");
        fid++;
        k = int'(dma_idx);
        wr_reg(3'd2, (k + 2) % SLOTS);
        run_frame(fid, 7, 0, "R5 after release");
        fid++;
        wr_reg(3'd2, k);

        // R6 length boundary
        k = int'(dma_idx);
        run_frame(fid, BUFSZ, 0, "R6 exact buffer");
        fid++;
        wr_reg(3'd2, k);
        k = int'(dma_idx);
        run_frame(fid, BUFSZ + 2, 0, "R6 oversize");
        fid++;
        wr_reg(3'd2, k);

        // R7 disabled engine ignores the stream
        wr_reg(3'd3, 0);
        k = int'(dma_idx);
        arm(k);
        s_valid = 1'b1; s_data = 8'h11;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(!s_ready && !rx_busy && !mem_we, "R7 disabled stays idle", int'(s_ready), 0);
        end
        s_valid = 1'b0;
        chk(data_cnt == 0 && !stat_seen && int'(dma_idx) == k, "R7 disabled no writes", data_cnt, 0);

        // R7 enable cleared mid-frame
        wr_reg(3'd3, 1);
        k = int'(dma_idx);
        arm(k);
        send_bytes(fid, 0, 4, 10);
        wr_reg(3'd3, 0);
        chk(rx_busy, "R9 busy during frame", int'(rx_busy), 1);
        send_bytes(fid, 4, 6, 10);
        wait_idle();
        verify_done(fid, k, 10, "R7 mid-frame disable");
        chk(!rx_busy, "R9 busy drops after frame", int'(rx_busy), 0);
        s_valid = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(!s_ready, "R7 no new frame after disable", int'(s_ready), 0);
        end
        s_valid = 1'b0;
        fid++;
        wr_reg(3'd2, k);
        wr_reg(3'd3, 1);

        // R8 index clear during a frame is deferred
        k = int'(dma_idx);
        arm(k);
        send_bytes(fid, 0, 3, 8);
        wr_reg(3'd4, 1);
        @(negedge clk);
        chk(int'(dma_idx) == k && rx_busy, "R8 clear deferred mid-frame", int'(dma_idx), k);
        send_bytes(fid, 3, 5, 8);
        wait_idle();
        @(negedge clk);
        chk(rd_word(BASE + 16*k + 8) == {2'b11, 14'd8, 16'h0}, "R8 frame completed at old index",
            int'(rd_word(BASE + 16*k + 8)), int'({2'b11, 14'd8, 16'h0}));
        chk(dma_idx == 0, "R8 index zero after deferred clear", int'(dma_idx), 0);
        fid++;

        // R8 index clear while idle
        wr_reg(3'd2, SLOTS - 1);
        run_frame(fid, 5, 0, "R8 pre-clear frame");
        fid++;
        wr_reg(3'd4, 1);
        repeat (3) @(negedge clk);
        chk(dma_idx == 0, "R8 idle clear", int'(dma_idx), 0);
        run_frame(fid, 4, 0, "R8 frame after clear");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule